// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a small 8-bit processor core is parked in a halted debug state and when it is let go. There are three ways in. The CPU can report that it executed a breakpoint instruction. A control write of 1 to the mode bit also enters debug mode. The third way uses the serial debug pin: its level is sampled on the last clock of a system reset, and if that level is low the core enters debug mode as soon as reset ends. The only way out is a control write of 0 to the mode bit.

The pin path at reset only works once the feature is unlocked. To unlock it, a parameterised 32-bit key is shifted in on the debug pin while the external reset pin is held low. Bits enter most significant first, one per rising clock edge. After unlocking, the feature stays unlocked until the next power-on reset.

While debug mode is active, the block stalls instruction fetch. The stall is lifted in any cycle where the debugger asks the core to execute an instruction. The block also refreshes the watchdog in every cycle while the watchdog is enabled. On entry, it sends a single-cycle request to take the core out of HALT. The controller is a four-state machine:

- RESET: system reset is in effect.
- RUN: normal execution.
- ENTER: the first active cycle, which carries the HALT-clear request.
- DEBUG: the remaining active cycles.

The transitions are:

- RESET goes to ENTER or RUN on reset release. It goes to ENTER only when the pin sampled low and the feature is unlocked.
- RUN goes to ENTER on a breakpoint or on a write of 1.
- ENTER goes to DEBUG by default. From ENTER or DEBUG, a write of 0 without a breakpoint leads to RUN.
- Any state goes to RESET while system reset is sampled high.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: In the cycle after system reset is sampled high, all four outputs are 0, and breakpoints and control writes during reset have no effect.
- R2: A breakpoint strobe sampled in RUN makes dbg_active and halt_clr 1 after that clock edge.
- R3: halt_clr is 1 only in the first cycle of each debug-mode stay and never in two consecutive cycles.
- R4: A control write with ctl_wdata = 0 while active, with no breakpoint strobe, makes dbg_active 0 after that edge. The same write outside debug mode has no effect.
- R5: A control write with ctl_wdata = 1 from RUN enters debug mode. The same write while already active has no effect.
- R6: If a breakpoint strobe and a write of 0 arrive in the same active cycle, debug mode stays active.
- R7: fetch_stall equals dbg_active AND NOT exec_req.
- R8: wdt_refresh equals dbg_active AND wdt_en, so it is asserted in every active cycle while the watchdog is enabled.
- R9: The feature unlocks only when all 32 key bits, shifted MSB first on consecutive edges within one low window of rst_pin_n, match the key. A partial key leaves it locked.
- R10: When unlocked, a low dbg_pin at the last edge with sys_rst high causes entry, with dbg_active and halt_clr 1 after the first edge with sys_rst low. The pin level at earlier reset cycles is irrelevant.
- R11: While locked, the pin level at reset is ignored. A wrong key leaves the feature locked. Unlock survives system reset and is cleared only by por_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst | input | 1 | System reset, active high, sampled |
| brk_exec | input | 1 | Breakpoint instruction executed strobe |
| dbg_pin | input | 1 | Serial debug pin level |
| rst_pin_n | input | 1 | External reset pin level, low = held in reset |
| ctl_wr | input | 1 | Write strobe to the debug control register |
| ctl_wdata | input | 1 | Value written to the debug-mode bit |
| exec_req | input | 1 | Debugger requests execution of an instruction |
| wdt_en | input | 1 | Watchdog timer enabled |
| fetch_stall | output | 1 | Stall the CPU fetch unit |
| halt_clr | output | 1 | Request to leave HALT, one cycle |
| wdt_refresh | output | 1 | Watchdog refresh |
| dbg_active | output | 1 | Debug-mode status bit |

## Verification
The assertions check the following on every cycle:

- Reset silences the outputs.
- Breakpoints and writes of 1 from RUN enter on the next edge.
- A write of 0 exits unless a breakpoint arrives with it.
- halt_clr never lasts two cycles.
- The stall never appears outside debug mode.
- Unlock happens only with the reset pin low, and it never reverts.

Other behaviour can only be shown by the bench's scenarios. These are whether a particular key sequence unlocks, whether a 31-bit or corrupted key is rejected, the last-cycle semantics of the reset pin sample, and the loss of unlock at power-on reset.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_ENTER = 2'd2,
        ST_DEBUG = 2'd3
    } dbg_state_e;

    typedef struct packed {
        logic brk;
        logic set_req;
        logic clr_req;
        logic boot_req;
    } dbg_evt_t;

endpackage

// File: rtl/dbg_key_unlock.sv
module dbg_key_unlock #(
    parameter int              KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY  = 32'hA5C3_1E69
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin_n,
    input  logic dbg_pin,
    output logic unlocked
);
    localparam int CNT_W = $clog2(KEY_W + 1);

    logic [KEY_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic [KEY_W-1:0] shreg_nxt;
    logic             last_bit;
    logic             full;

    assign shreg_nxt = {shreg[KEY_W-2:0], dbg_pin};
    assign last_bit  = (cnt == CNT_W'(KEY_W - 1));
    assign full      = (cnt == CNT_W'(KEY_W));

    // Capture window: only while the reset pin is low; a completed
    // window (match or not) saturates until the pin goes high again.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            shreg    <= '0;
            cnt      <= '0;
            unlocked <= 1'b0;
        end else if (rst_pin_n) begin
            cnt <= '0;
        end else if (!full) begin
            shreg <= shreg_nxt;
            cnt   <= cnt + CNT_W'(1);
            if (last_bit && (shreg_nxt == KEY))
                unlocked <= 1'b1;
        end
    end

    a_r11_unlock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        unlocked |=> unlocked);

    a_r9_unlock_in_window: assert property (@(posedge clk) disable iff (!por_n)
        $rose(unlocked) |-> $past(!rst_pin_n));

    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= CNT_W'(KEY_W));

endmodule

// File: rtl/dbg_boot_sampler.sv
module dbg_boot_sampler (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic dbg_pin,
    output logic pin_low_last
);
    // Holds the pin level seen at the most recent edge with reset high.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            pin_low_last <= 1'b0;
        else if (sys_rst)
            pin_low_last <= !dbg_pin;
    end

    a_r10_hold_outside_reset: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst |=> $stable(pin_low_last));

endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_entry_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     sys_rst,
    input  dbg_evt_t evt,
    input  logic     exec_req,
    input  logic     wdt_en,
    output logic     dbg_active,
    output logic     halt_clr,
    output logic     fetch_stall,
    output logic     wdt_refresh
);
    dbg_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET: state_nxt = evt.boot_req ? ST_ENTER : ST_RUN;
            ST_RUN:   if (evt.brk || evt.set_req) state_nxt = ST_ENTER;
            ST_ENTER,
            ST_DEBUG: state_nxt = (evt.clr_req && !evt.brk) ? ST_RUN : ST_DEBUG;
            default:  state_nxt = ST_RESET;
        endcase
        if (sys_rst)
            state_nxt = ST_RESET;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state <= ST_RESET;
        else
            state <= state_nxt;
    end

    always_comb begin
        dbg_active  = 1'b0;
        halt_clr    = 1'b0;
        unique case (state)
            ST_RESET,
            ST_RUN:   ;
            ST_ENTER: begin
                dbg_active = 1'b1;
                halt_clr   = 1'b1;
            end
            ST_DEBUG: dbg_active = 1'b1;
            default:  ;
        endcase
        fetch_stall = dbg_active && !exec_req;
        wdt_refresh = dbg_active && wdt_en;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> (!dbg_active && !halt_clr && !fetch_stall && !wdt_refresh));

    a_r2_brk_enters: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && evt.brk && !sys_rst) |=> (dbg_active && halt_clr));

    a_r3_halt_clr_single: assert property (@(posedge clk) disable iff (!por_n)
        halt_clr |=> !halt_clr);

    a_r4_clear_exits: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_active && evt.clr_req && !evt.brk && !sys_rst) |=> !dbg_active);

    a_r5_set_enters: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && evt.set_req && !sys_rst) |=> dbg_active);

    a_r6_entry_wins: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_active && evt.brk && !sys_rst) |=> dbg_active);

    a_r10_boot_entry: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RESET && evt.boot_req && !sys_rst) |=> halt_clr);

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int               KEY_W      = 32,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 32'hA5C3_1E69
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic brk_exec,
    input  logic dbg_pin,
    input  logic rst_pin_n,
    input  logic ctl_wr,
    input  logic ctl_wdata,
    input  logic exec_req,
    input  logic wdt_en,
    output logic fetch_stall,
    output logic halt_clr,
    output logic wdt_refresh,
    output logic dbg_active
);
    logic     unlocked;
    logic     pin_low_last;
    dbg_evt_t evt;

    dbg_key_unlock #(
        .KEY_W (KEY_W),
        .KEY   (UNLOCK_KEY)
    ) u_unlock (
        .clk       (clk),
        .por_n     (por_n),
        .rst_pin_n (rst_pin_n),
        .dbg_pin   (dbg_pin),
        .unlocked  (unlocked)
    );

    dbg_boot_sampler u_boot (
        .clk          (clk),
        .por_n        (por_n),
        .sys_rst      (sys_rst),
        .dbg_pin      (dbg_pin),
        .pin_low_last (pin_low_last)
    );

    always_comb begin
        evt.brk      = brk_exec;
        evt.set_req  = ctl_wr && ctl_wdata;
        evt.clr_req  = ctl_wr && !ctl_wdata;
        evt.boot_req = pin_low_last && unlocked;
    end

    dbg_mode_fsm u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .sys_rst     (sys_rst),
        .evt         (evt),
        .exec_req    (exec_req),
        .wdt_en      (wdt_en),
        .dbg_active  (dbg_active),
        .halt_clr    (halt_clr),
        .fetch_stall (fetch_stall),
        .wdt_refresh (wdt_refresh)
    );

    a_r7_stall_needs_active: assert property (@(posedge clk) disable iff (!por_n)
        fetch_stall |-> dbg_active);

    a_r8_refresh_needs_active: assert property (@(posedge clk) disable iff (!por_n)
        wdt_refresh |-> (dbg_active && wdt_en));

    a_r11_locked_no_boot: assert property (@(posedge clk) disable iff (!por_n)
        (!unlocked && !dbg_active && !brk_exec && !ctl_wr) |=> !halt_clr);

endmodule

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;

    localparam int          KW  = 32;
    localparam logic [31:0] KEY = 32'hA5C3_1E69;
    localparam int          NV  = 17;

    // {sys_rst, brk, wr, wdata, exec_req, wdt_en, A, S, H, W}
    localparam logic [9:0] VEC [NV] = '{
        10'b000001_0000, 10'b010001_1111, 10'b000001_1101, 10'b000010_1000,
        10'b001101_1101, 10'b011001_1101, 10'b001001_0000, 10'b001001_0000,
        10'b001111_1011, 10'b001000_0000, 10'b000011_0000, 10'b010000_1110,
        10'b100001_0000, 10'b111101_0000, 10'b000001_0000, 10'b010001_1111,
        10'b001001_0000
    };
    string tags [NV] = '{
        "R5 idle", "R2 brk entry", "R8 refresh", "R7 exec lifts stall",
        "R5 set ignored when active", "R6 entry wins", "R4 exit", "R4 clear in run",
        "R5 set entry", "R4 exit from first cycle", "R7 exec in run", "R3 entry pulse",
        "R1 reset", "R1 events in reset", "R10 locked release", "R2 brk again",
        "R4 exit again"
    };

    logic clk = 1'b0;
    logic por_n = 1'b0, sys_rst = 1'b1, brk_exec = 1'b0, dbg_pin = 1'b1;
    logic rst_pin_n = 1'b1, ctl_wr = 1'b0, ctl_wdata = 1'b0;
    logic exec_req = 1'b0, wdt_en = 1'b0;
    logic fetch_stall, halt_clr, wdt_refresh, dbg_active;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dbg_entry_ctrl u_dut (
        .clk (clk), .por_n (por_n), .sys_rst (sys_rst), .brk_exec (brk_exec),
        .dbg_pin (dbg_pin), .rst_pin_n (rst_pin_n), .ctl_wr (ctl_wr),
        .ctl_wdata (ctl_wdata), .exec_req (exec_req), .wdt_en (wdt_en),
        .fetch_stall (fetch_stall), .halt_clr (halt_clr),
        .wdt_refresh (wdt_refresh), .dbg_active (dbg_active)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [3:0] exp);
        chk({req, " dbg_active"},  dbg_active,  exp[3]);
        chk({req, " fetch_stall"}, fetch_stall, exp[2]);
        chk({req, " halt_clr"},    halt_clr,    exp[1]);
        chk({req, " wdt_refresh"}, wdt_refresh, exp[0]);
    endtask

    task automatic shift_key(input logic [31:0] k, input int nbits);
        rst_pin_n = 1'b0;
        for (int b = KW - 1; b >= KW - nbits; b--) begin
            dbg_pin = k[b];
            tick();
        end
        rst_pin_n = 1'b1;
        dbg_pin   = 1'b1;
        tick();
    endtask

    // Reset pulse: pin low only on the last reset edge when last_low is set.
    task automatic boot(input logic early_low, input logic last_low);
        sys_rst = 1'b1;
        dbg_pin = !early_low;
        tick();
        dbg_pin = !last_low;
        tick();
        sys_rst = 1'b0;
        dbg_pin = 1'b1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        chk_all("R1 power-on reset", 4'b0000);
        por_n = 1'b1;
        tick(); tick();
        sys_rst = 1'b0;
        tick();
        chk_all("R1 after release", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            {sys_rst, brk_exec, ctl_wr, ctl_wdata, exec_req, wdt_en} = VEC[i][9:4];
            tick();
            chk_all(tags[i], VEC[i][3:0]);
        end
        {sys_rst, brk_exec, ctl_wr, ctl_wdata, exec_req, wdt_en} = 6'b000001;
        tick();

        // R11: locked, pin low on last reset cycle ignored
        boot(1'b1, 1'b1);
        chk("R11 locked boot ignored", dbg_active, 1'b0);

        // R9: 31 of 32 bits only
        shift_key(KEY, KW - 1);
        boot(1'b1, 1'b1);
        chk("R9 partial key stays locked", dbg_active, 1'b0);

        // R11: wrong key
        shift_key(KEY ^ 32'h0000_0001, KW);
        boot(1'b1, 1'b1);
        chk("R11 wrong key stays locked", dbg_active, 1'b0);

        // R9: correct key unlocks
        shift_key(KEY, KW);
        // R10: low only on an earlier reset cycle does not enter
        boot(1'b1, 1'b0);
        chk("R10 early low ignored", dbg_active, 1'b0);
        boot(1'b0, 1'b1);
        chk("R9 R10 boot entry active", dbg_active, 1'b1);
        chk("R10 boot entry halt_clr", halt_clr, 1'b1);
        tick();
        chk("R3 halt_clr drops", halt_clr, 1'b0);
        chk("R8 refresh held", wdt_refresh, 1'b1);
        ctl_wr = 1'b1; ctl_wdata = 1'b0;
        tick();
        ctl_wr = 1'b0;
        chk("R4 exit after boot entry", dbg_active, 1'b0);

        // R11: unlock survives system reset
        boot(1'b0, 1'b1);
        chk("R11 unlock kept over sys reset", dbg_active, 1'b1);
        ctl_wr = 1'b1; ctl_wdata = 1'b0;
        tick();
        ctl_wr = 1'b0;

        // R11: power-on reset relocks
        por_n = 1'b0; sys_rst = 1'b1;
        tick();
        por_n = 1'b1;
        tick();
        boot(1'b0, 1'b1);
        chk("R11 relocked after por", dbg_active, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule